// File: doc/BRIEF.md
# DSP Interface Control and Interrupt Register

This block is the 16-bit control and status word that a host processor uses to steer a DSP core and to collect its interrupts. Three sources report events into it: the DSP itself, the auxiliary-RAM DMA engine and the audio DMA engine. Each event sets a sticky status bit. Each status bit has an enable bit placed one position above it. A single interrupt line goes to the processor interface. It is high whenever a status bit and the enable bit next to it are both set. Software clears a status bit by writing a one into its position.

The same word holds the DSP control bits: reset, assert-interrupt, halt, init-code and init. It also holds a read-only DMA-busy flag, taken live from the DMA engine, and a four-bit padding field. Writing the reset bit sends a one-cycle strobe to the audio DMA logic, which clears that engine's control register. Writing a nonzero padding value stores the value and raises a one-cycle error flag. Two neighbouring registers share the same small select bus. One is the memory-controller mode register, which always reports an initialised controller. The other is a refresh register, which is plain storage.

Top module: `dspif_ctrl_regs`

## Requirements
- R1: `irq` is high exactly when some source has both its status bit and its enable bit set. The status/enable pairs are: audio at bits 3/4, auxiliary RAM at bits 5/6, DSP at bits 7/8.
- R2: After reset, the control word reads 0x0004 (only halt set) and `irq` is low. The refresh register reads 156 (0x009C).
- R3: On a control write (`sel`=0), a 1 in status bit 3, 5 or 7 clears that bit, and a 0 leaves it unchanged.
- R4: A pulse on `evt[s]` (bit 0 audio, bit 1 auxiliary RAM, bit 2 DSP) sets that source's status bit. If the pulse and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R5: A control write loads bits 0 (reset), 1 (assert-interrupt), 2 (halt), 10 (init-code), 11 (init) and enable bits 4, 6, 8 from the written data. These bits read back and drive the matching `dsp_*` outputs.
- R6: Bit 9 of the control word always reads `dma_busy`, and control writes have no effect on it.
- R7: A control write with bit 0 set makes `audio_dma_clr` high for exactly the next cycle.
- R8: Bits 15:12 keep the written padding value. A control write with a nonzero padding value makes `pad_err` high for exactly the next cycle.
- R9: The mode register (`sel`=1) always reads 0x0001, and writes to it have no effect.
- R10: The refresh register (`sel`=2) reads the last value written to it. `sel`=3 reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register chosen by `sel` |
| sel | input | 2 | Register select: 0 control, 1 mode, 2 refresh, 3 none |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data of the selected register |
| evt | input | 3 | Interrupt event pulses: bit 0 audio, bit 1 aux RAM, bit 2 DSP |
| dma_busy | input | 1 | Busy flag from the auxiliary-RAM DMA engine |
| irq | output | 1 | Interrupt line to the processor interface |
| audio_dma_clr | output | 1 | One-cycle strobe that clears the audio DMA control |
| pad_err | output | 1 | One-cycle flag for a nonzero padding write |
| dsp_reset | output | 1 | DSP reset control bit |
| dsp_assert_int | output | 1 | Assert-interrupt control bit |
| dsp_halt | output | 1 | DSP halt control bit |
| dsp_init_code | output | 1 | Init-code control bit |
| dsp_init | output | 1 | Init control bit |

## Verification
The assertions assume that `evt` bits are clean one-cycle pulses sampled on the rising edge. They also assume that `sel` and `wdata` are stable whenever `wr_en` is high. The stimulus changes every input only on the falling clock edge, so inputs are settled before each rising edge. It raises each event bit for one cycle only. The exhaustive sweep covers every enable pattern against every event pattern. The set-versus-clear collision is driven on purpose, in one cycle, to exercise the priority rule.

// File: rtl/dspif_pkg.sv
package dspif_pkg;
  localparam int REG_W     = 16;
  localparam int NSRC      = 3;
  localparam int BIT_RESET = 0;
  localparam int BIT_AINT  = 1;
  localparam int BIT_HALT  = 2;
  localparam int BIT_BUSY  = 9;
  localparam int BIT_ICODE = 10;
  localparam int BIT_INIT  = 11;
  localparam int PAD_LSB   = 12;
  localparam int PAD_W     = REG_W - PAD_LSB;
  localparam int REFRESH_RESET = 156;

  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_MODE    = 2'd1,
    SEL_REFRESH = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;

  // Status bit of source s; its enable sits one place above.
  function automatic int stat_bit(input int s);
    return 3 + 2 * s;
  endfunction

  function automatic logic [REG_W-1:0] stat_select();
    logic [REG_W-1:0] m;
    m = '0;
    for (int s = 0; s < NSRC; s++) m[stat_bit(s)] = 1'b1;
    return m;
  endfunction

  // Shift-AND-reduce: status bit n gated by the enable at n+1.
  function automatic logic irq_of(input logic [REG_W-1:0] w);
    return |((w >> 1) & w & stat_select());
  endfunction
endpackage

// File: rtl/dspif_status_bits.sv
module dspif_status_bits #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  for (genvar s = 0; s < N; s++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          stat_o[s] <= 1'b0;
      else if (set_i[s])   stat_o[s] <= 1'b1;  // set beats clear
      else if (clr_i[s])   stat_o[s] <= 1'b0;
    end
  end
endmodule

// File: rtl/dspif_irq_reduce.sv
module dspif_irq_reduce
  import dspif_pkg::*;
(
  input  logic [REG_W-1:0] word_i,
  output logic             irq_o
);
  always_comb irq_o = irq_of(word_i);
endmodule

// File: rtl/dspif_aux_regs.sv
module dspif_aux_regs #(
  parameter int W = 16,
  parameter int REFRESH_INIT = 156
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_refresh,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] refresh_o,
  output logic [W-1:0] mode_o
);
  localparam logic [W-1:0] MODE_READY = W'(1);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          refresh_o <= W'(REFRESH_INIT);
    else if (wr_refresh) refresh_o <= wdata;
  end
  assign mode_o = MODE_READY;
endmodule

// File: rtl/dspif_ctrl_regs.sv
module dspif_ctrl_regs
  import dspif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       sel,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic [NSRC-1:0]  evt,
  input  logic             dma_busy,
  output logic             irq,
  output logic             audio_dma_clr,
  output logic             pad_err,
  output logic             dsp_reset,
  output logic             dsp_assert_int,
  output logic             dsp_halt,
  output logic             dsp_init_code,
  output logic             dsp_init
);
  logic             wr_ctrl;
  logic [NSRC-1:0]  clr_req;
  logic [NSRC-1:0]  stat_q;
  logic [NSRC-1:0]  mask_q;
  logic [PAD_W-1:0] pad_q;
  logic             rst_q, aint_q, halt_q, icode_q, init_q;
  logic [REG_W-1:0] ctrl_word;
  logic [REG_W-1:0] refresh_w, mode_w;
  logic             clr_strobe_q, pad_err_q;

  assign wr_ctrl = wr_en && (sel == SEL_CTRL);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign clr_req[s] = wr_ctrl && wdata[stat_bit(s)];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q[s] <= 1'b0;
      else if (wr_ctrl) mask_q[s] <= wdata[stat_bit(s) + 1];
    end
  end

  dspif_status_bits #(.N(NSRC)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_i(evt), .clr_i(clr_req), .stat_o(stat_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b0; aint_q <= 1'b0; halt_q <= 1'b1;
      icode_q <= 1'b0; init_q <= 1'b0; pad_q <= '0;
      clr_strobe_q <= 1'b0; pad_err_q <= 1'b0;
    end else begin
      clr_strobe_q <= wr_ctrl && wdata[BIT_RESET];
      pad_err_q    <= wr_ctrl && (wdata[REG_W-1:PAD_LSB] != '0);
      if (wr_ctrl) begin
        rst_q   <= wdata[BIT_RESET];
        aint_q  <= wdata[BIT_AINT];
        halt_q  <= wdata[BIT_HALT];
        icode_q <= wdata[BIT_ICODE];
        init_q  <= wdata[BIT_INIT];
        pad_q   <= wdata[REG_W-1:PAD_LSB];
      end
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[BIT_RESET] = rst_q;
    ctrl_word[BIT_AINT]  = aint_q;
    ctrl_word[BIT_HALT]  = halt_q;
    for (int s = 0; s < NSRC; s++) begin
      ctrl_word[stat_bit(s)]     = stat_q[s];
      ctrl_word[stat_bit(s) + 1] = mask_q[s];
    end
    ctrl_word[BIT_BUSY]  = dma_busy;
    ctrl_word[BIT_ICODE] = icode_q;
    ctrl_word[BIT_INIT]  = init_q;
    ctrl_word[REG_W-1:PAD_LSB] = pad_q;
  end

  dspif_irq_reduce u_irq (.word_i(ctrl_word), .irq_o(irq));

  dspif_aux_regs #(.W(REG_W), .REFRESH_INIT(REFRESH_RESET)) u_aux (
    .clk(clk), .rst_n(rst_n),
    .wr_refresh(wr_en && (sel == SEL_REFRESH)),
    .wdata(wdata), .refresh_o(refresh_w), .mode_o(mode_w)
  );

  always_comb begin
    case (sel)
      SEL_CTRL:    rdata = ctrl_word;
      SEL_MODE:    rdata = mode_w;
      SEL_REFRESH: rdata = refresh_w;
      default:     rdata = '0;
    endcase
  end

  assign audio_dma_clr  = clr_strobe_q;
  assign pad_err        = pad_err_q;
  assign dsp_reset      = rst_q;
  assign dsp_assert_int = aint_q;
  assign dsp_halt       = halt_q;
  assign dsp_init_code  = icode_q;
  assign dsp_init       = init_q;
endmodule

// File: rtl/dspif_ctrl_checker.sv
module dspif_ctrl_checker
  import dspif_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       sel,
  input logic [REG_W-1:0] wdata,
  input logic [REG_W-1:0] rdata,
  input logic [NSRC-1:0]  evt,
  input logic [NSRC-1:0]  stat,
  input logic [NSRC-1:0]  mask,
  input logic             dma_busy,
  input logic             irq,
  input logic             audio_dma_clr,
  input logic             pad_err
);
  logic wr_c;
  assign wr_c = wr_en && (sel == SEL_CTRL);

  a_r1_irq_matches: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(stat & mask));

  for (genvar s = 0; s < NSRC; s++) begin : g_chk
    a_r4_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
      evt[s] |=> stat[s]);
    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_c && wdata[stat_bit(s)] && !evt[s]) |=> !stat[s]);
    a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_c && !wdata[stat_bit(s)] && stat[s]) |=> stat[s]);
    a_r5_mask_loads: assert property (@(posedge clk) disable iff (!rst_n)
      wr_c |=> mask[s] == $past(wdata[stat_bit(s) + 1]));
  end

  a_r6_busy_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_CTRL) |-> rdata[BIT_BUSY] == dma_busy);
  a_r7_clr_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && wdata[BIT_RESET]) |=> audio_dma_clr);
  a_r7_clr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_c |=> !audio_dma_clr);
  a_r8_pad_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && wdata[REG_W-1:PAD_LSB] != '0) |=> pad_err);
  a_r9_mode_one: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_MODE) |-> rdata == REG_W'(1));
endmodule

bind dspif_ctrl_regs dspif_ctrl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(wdata),
  .rdata(rdata), .evt(evt), .stat(stat_q), .mask(mask_q),
  .dma_busy(dma_busy), .irq(irq), .audio_dma_clr(audio_dma_clr),
  .pad_err(pad_err)
);

// File: tb/dspif_ctrl_regs_test.sv
`timescale 1ns/1ps
module dspif_ctrl_regs_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [1:0]  sel = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic [2:0]  evt = 0;
  logic        dma_busy = 0;
  logic        irq, audio_dma_clr, pad_err;
  logic        dsp_reset, dsp_assert_int, dsp_halt, dsp_init_code, dsp_init;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  logic [2:0] m_stat, m_mask;
  logic       m_rst, m_aint, m_halt, m_icode, m_init;
  logic [3:0] m_pad;

  always #2 clk = ~clk;

  dspif_ctrl_regs uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(wdata),
    .rdata(rdata), .evt(evt), .dma_busy(dma_busy), .irq(irq),
    .audio_dma_clr(audio_dma_clr), .pad_err(pad_err),
    .dsp_reset(dsp_reset), .dsp_assert_int(dsp_assert_int),
    .dsp_halt(dsp_halt), .dsp_init_code(dsp_init_code), .dsp_init(dsp_init)
  );

  function automatic int model_word();
    return m_rst + 2*m_aint + 4*m_halt + 8*m_stat[0] + 16*m_mask[0]
         + 32*m_stat[1] + 64*m_mask[1] + 128*m_stat[2] + 256*m_mask[2]
         + 512*dma_busy + 1024*m_icode + 2048*m_init + 4096*m_pad;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Drive on falling edge; after the next falling edge the write has landed.
  task automatic cycle(input logic w, input logic [1:0] s, input logic [15:0] d,
                       input logic [2:0] e);
    @(negedge clk);
    wr_en = w; sel = s; wdata = d; evt = e;
    @(negedge clk);
    wr_en = 0; evt = 0;
    if (w && s == 2'd0) begin
      m_rst = d[0]; m_aint = d[1]; m_halt = d[2]; m_icode = d[10]; m_init = d[11];
      m_mask = {d[8], d[6], d[4]};
      m_pad = d[15:12];
      m_stat = m_stat & ~{d[7], d[5], d[3]};
    end
    m_stat = m_stat | e;
  endtask

  task automatic rd(input logic [1:0] s, output int v);
    sel = s; #1; v = rdata;
  endtask

  int v;

  initial begin
    m_stat = 0; m_mask = 0; m_rst = 0; m_aint = 0; m_halt = 1;
    m_icode = 0; m_init = 0; m_pad = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(2'd0, v); chk("R2 ctrl reset", v, 16'h0004);
    chk("R2 irq reset", irq, 0);
    rd(2'd2, v); chk("R2 refresh reset", v, 156);
    rd(2'd1, v); chk("R9 mode reads one", v, 1);

    // R1/R3/R4 sweep: every enable pattern against every event pattern
    for (int m = 0; m < 8; m++) begin
      for (int e = 0; e < 8; e++) begin
        logic [15:0] d;
        d = 16'h00A8 | 16'h0004 | (16'(m & 1) << 4) | (16'((m >> 1) & 1) << 6)
            | (16'((m >> 2) & 1) << 8);
        cycle(1, 2'd0, d, 3'd0);
        cycle(0, 2'd0, 16'h0, 3'(e));
        chk("R1 irq", irq, ((m & e) != 0) ? 1 : 0);
        rd(2'd0, v); chk("R4 status after events", v, model_word());
      end
    end

    // R3 selective clear
    cycle(1, 2'd0, 16'h0004, 3'b111);
    cycle(1, 2'd0, 16'h0024, 3'd0);
    rd(2'd0, v); chk("R3 clear aux only", v & 16'h00A8, 16'h0088);
    // R4 set wins over clear in same cycle
    cycle(1, 2'd0, 16'h0184, 3'b100);
    rd(2'd0, v); chk("R4 set beats clear", (v >> 7) & 1, 1);
    chk("R1 dsp irq enabled", irq, 1);

    // R5/R7 control bits and reset strobe
    cycle(1, 2'd0, 16'h0C03, 3'd0);
    chk("R7 clr strobe high", audio_dma_clr, 1);
    chk("R5 outputs", {dsp_init, dsp_init_code, dsp_halt, dsp_assert_int, dsp_reset},
        5'b11011);
    rd(2'd0, v); chk("R5 readback", v, model_word());
    cycle(0, 2'd0, 16'h0, 3'd0);
    chk("R7 clr strobe one cycle", audio_dma_clr, 0);
    cycle(1, 2'd0, 16'h0004, 3'd0);
    chk("R7 no strobe without bit0", audio_dma_clr, 0);
    chk("R5 halt set", dsp_halt, 1);

    // R6 busy passthrough, writes ignored
    dma_busy = 1; rd(2'd0, v); chk("R6 busy reads one", (v >> 9) & 1, 1);
    dma_busy = 0; cycle(1, 2'd0, 16'h0204, 3'd0);
    rd(2'd0, v); chk("R6 write ignored", (v >> 9) & 1, 0);

    // R8 padding
    cycle(1, 2'd0, 16'hA004, 3'd0);
    chk("R8 pad err", pad_err, 1);
    rd(2'd0, v); chk("R8 pad kept", v >> 12, 4'hA);
    cycle(1, 2'd0, 16'h0004, 3'd0);
    chk("R8 no pad err", pad_err, 0);

    // R9/R10 neighbouring registers
    cycle(1, 2'd1, 16'h1234, 3'd0);
    rd(2'd1, v); chk("R9 mode write ignored", v, 1);
    rd(2'd0, v); chk("R9 ctrl untouched", v, model_word());
    cycle(1, 2'd2, 16'h0123, 3'd0);
    rd(2'd2, v); chk("R10 refresh stored", v, 16'h0123);
    rd(2'd3, v); chk("R10 unused reads zero", v, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule